// File: doc/BRIEF.md
# Register Bank Address Mapper

This block turns an 8-bit direct register operand, an access size and the current register bank selection into a 10-bit physical address. The target is a 1 KiB on-chip register space made of four 256-byte banks. The mapping itself is combinational. A small amount of state sits beside it: a bank select register and a one-instruction bank-0 override flag.

A word access whose operand address is odd is not treated as misaligned. It is redirected into the next 256-byte region, at the even word address plus 0x100. This lets one 8-bit operand field reach a second register bank.

Byte accesses are never redirected. The special-function window at 0x00 to 0x23 always sits in bank 0. General registers at 0x24 and above follow the selected data bank unless the override is active. Operand 0x00 is flagged so that the datapath can force a zero value.

Top module: `regbank_addr_map`

## Requirements
- R1: A word access (is_word=1) with an odd operand address maps to {2'b01, opnd_addr[7:1], 1'b0}, which is the even word address plus 0x100. This holds for every odd operand, including those inside 0x00..0x23.
- R2: A byte access (is_word=0) is never redirected. phys_addr[7:0] equals opnd_addr, so odd 8-bit special registers are reached directly.
- R3: A non-redirected access to operand 0x00..0x23 maps to bank 0 (phys_addr[9:8]=0), whatever the select register or override holds.
- R4: A non-redirected access to operand 0x24..0xFF maps to {data_bank, opnd_addr}. data_bank is bits [1:0] of the select register. Bits [3:2] of that 4-bit field are ignored.
- R5: After reset the select register holds 0x11. This selects data bank 1 and stack bank 1, and stack_bank shows select bits [5:4].
- R6: A write on sel_we loads sel_wdata at the rising clock edge. The new banks take effect from the next cycle.
- R7: A bank0_cmd pulse sets the override from the next cycle on. While the override is set, operands 0x24..0xFF that are not redirected map to bank 0. An insn_done pulse clears the override. If bank0_cmd and insn_done arrive in the same cycle, the flag is set.
- R8: sfr_hit is 1 exactly when phys_addr is in 0x000..0x023.
- R9: zero_force is 1 exactly when the access is not redirected and opnd_addr is 0x00. In that case phys_addr is 0x000.
- R10: The select register value and the override have no effect on the address of a redirected word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_addr | input | 8 | Direct operand address |
| is_word | input | 1 | 1 = word access, 0 = byte access |
| bank0_cmd | input | 1 | Bank-0 override command strobe |
| insn_done | input | 1 | Instruction-complete pulse |
| sel_we | input | 1 | Select register write enable |
| sel_wdata | input | 8 | Select register write data (low nibble data bank, high nibble stack bank) |
| phys_addr | output | 10 | Physical register address |
| sfr_hit | output | 1 | Physical address is in the special-function window |
| zero_force | output | 1 | Operand is the zero register |
| stack_bank | output | 2 | Active stack bank |

## Verification
The bound checker tests four things on every cycle:
- the redirect formula for odd words;
- byte pass-through;
- the SFR window staying in bank 0 with sfr_hit consistent against the address;
- the zero flag.

It also checks that an override set by the previous cycle's strobe pulls general registers into bank 0.

Some behaviour can only be shown by the bench's scenarios:
- the boot value of the select register;
- select writes taking effect, with the ignored upper field bits;
- the override surviving until the instruction-complete pulse, then clearing, and its set-wins priority;
- redirected words staying put under every bank setting.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int OPND_W   = 8;
    localparam int BANK_W   = 2;
    localparam int PHYS_W   = OPND_W + BANK_W;
    localparam int FIELD_W  = 4;
    localparam int SEL_W    = 2 * FIELD_W;
    localparam logic [OPND_W-1:0] SFR_LAST  = 8'h23;
    localparam logic [SEL_W-1:0]  SEL_BOOT  = 8'h11;
    localparam logic [BANK_W-1:0] REDIR_BANK = 2'd1;

    typedef enum logic [1:0] {
        MAP_REDIRECT,
        MAP_SFR,
        MAP_BANKED
    } map_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] data_bank;
        logic [BANK_W-1:0] stack_bank;
        logic              force_bank0;
    } bank_ctx_t;

    typedef struct packed {
        logic [PHYS_W-1:0] addr;
        logic              sfr;
        logic              zero;
    } map_out_t;

    function automatic map_kind_e classify(input logic [OPND_W-1:0] a, input logic word);
        if (word && a[0])
            return MAP_REDIRECT;
        else if (a <= SFR_LAST)
            return MAP_SFR;
        else
            return MAP_BANKED;
    endfunction
endpackage

// File: rtl/bank_select.sv
module bank_select
    import regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             bank0_cmd,
    input  logic             insn_done,
    output bank_ctx_t        ctx
);
    logic [SEL_W-1:0] sel_q;
    logic             ovr_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= SEL_BOOT;
        else if (sel_we)
            sel_q <= sel_wdata;
    end

    // strobe wins over completion so the command's own done pulse cannot clear it
    always_ff @(posedge clk) begin
        if (rst)
            ovr_q <= 1'b0;
        else if (bank0_cmd)
            ovr_q <= 1'b1;
        else if (insn_done)
            ovr_q <= 1'b0;
    end

    logic [FIELD_W-1:0] data_field;
    logic [FIELD_W-1:0] stack_field;
    assign data_field  = sel_q[FIELD_W-1:0];
    assign stack_field = sel_q[SEL_W-1:FIELD_W];

    assign ctx.data_bank   = data_field[BANK_W-1:0];
    assign ctx.stack_bank  = stack_field[BANK_W-1:0];
    assign ctx.force_bank0 = ovr_q;

    logic unused_bits;
    assign unused_bits = ^{data_field[FIELD_W-1:BANK_W], stack_field[FIELD_W-1:BANK_W]};
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import regbank_pkg::*;
(
    input  logic [OPND_W-1:0] opnd_addr,
    input  logic              is_word,
    input  bank_ctx_t         ctx,
    output map_out_t          mo
);
    map_kind_e         kind;
    logic [BANK_W-1:0] bank;

    always_comb begin
        kind = classify(opnd_addr, is_word);
        bank = ctx.force_bank0 ? '0 : ctx.data_bank;
        mo   = '0;
        unique case (kind)
            MAP_REDIRECT: mo.addr = {REDIR_BANK, opnd_addr[OPND_W-1:1], 1'b0};
            MAP_SFR:      mo.addr = {{BANK_W{1'b0}}, opnd_addr};
            default:      mo.addr = {bank, opnd_addr};
        endcase
        mo.sfr  = (mo.addr[PHYS_W-1:OPND_W] == '0) && (mo.addr[OPND_W-1:0] <= SFR_LAST);
        mo.zero = (kind != MAP_REDIRECT) && (opnd_addr == '0);
    end
endmodule

// File: rtl/regbank_addr_map.sv
module regbank_addr_map
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        opnd_addr,
    input  logic              is_word,
    input  logic              bank0_cmd,
    input  logic              insn_done,
    input  logic              sel_we,
    input  logic [7:0]        sel_wdata,
    output logic [9:0]        phys_addr,
    output logic              sfr_hit,
    output logic              zero_force,
    output logic [1:0]        stack_bank
);
    bank_ctx_t ctx;
    map_out_t  mo;

    bank_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .bank0_cmd (bank0_cmd),
        .insn_done (insn_done),
        .ctx       (ctx)
    );

    addr_xlate u_xl (
        .opnd_addr (opnd_addr),
        .is_word   (is_word),
        .ctx       (ctx),
        .mo        (mo)
    );

    assign phys_addr  = mo.addr;
    assign sfr_hit    = mo.sfr;
    assign zero_force = mo.zero;
    assign stack_bank = ctx.stack_bank;
endmodule

// File: rtl/regbank_addr_map_chk.sv
module regbank_addr_map_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] opnd_addr,
    input logic       is_word,
    input logic       bank0_cmd,
    input logic [9:0] phys_addr,
    input logic       sfr_hit,
    input logic       zero_force
);
    assert_odd_word_redirect_R1: assert property (@(posedge clk) disable iff (rst)
        (is_word && opnd_addr[0]) |-> (phys_addr == ({2'b00, opnd_addr & 8'hFE} + 10'h100)));

    assert_byte_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        !is_word |-> (phys_addr[7:0] == opnd_addr));

    assert_sfr_bank0_R3: assert property (@(posedge clk) disable iff (rst)
        (!(is_word && opnd_addr[0]) && opnd_addr <= 8'h23) |-> (phys_addr[9:8] == 2'd0));

    assert_override_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(bank0_cmd) && !is_word && opnd_addr >= 8'h24) |-> (phys_addr[9:8] == 2'd0));

    assert_sfr_flag_R8: assert property (@(posedge clk) disable iff (rst)
        sfr_hit == (phys_addr <= 10'h023));

    assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
        zero_force |-> (phys_addr == 10'h000 && opnd_addr == 8'h00));
endmodule

bind regbank_addr_map regbank_addr_map_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .opnd_addr  (opnd_addr),
    .is_word    (is_word),
    .bank0_cmd  (bank0_cmd),
    .phys_addr  (phys_addr),
    .sfr_hit    (sfr_hit),
    .zero_force (zero_force)
);

// File: tb/regbank_addr_map_tb.sv
module regbank_addr_map_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] opnd_addr;
    logic       is_word;
    logic       bank0_cmd;
    logic       insn_done;
    logic       sel_we;
    logic [7:0] sel_wdata;
    logic [9:0] phys_addr;
    logic       sfr_hit;
    logic       zero_force;
    logic [1:0] stack_bank;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    regbank_addr_map u_dut (
        .clk(clk), .rst(rst), .opnd_addr(opnd_addr), .is_word(is_word),
        .bank0_cmd(bank0_cmd), .insn_done(insn_done), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .phys_addr(phys_addr), .sfr_hit(sfr_hit),
        .zero_force(zero_force), .stack_bank(stack_bank)
    );

    // {is_word, opnd, exp_phys, exp_sfr, exp_zero} with data bank 1, no override
    localparam logic [20:0] VEC [12] = '{
        {1'b0, 8'h00, 10'h000, 1'b1, 1'b1},
        {1'b0, 8'h15, 10'h015, 1'b1, 1'b0},
        {1'b1, 8'h14, 10'h014, 1'b1, 1'b0},
        {1'b1, 8'h15, 10'h114, 1'b0, 1'b0},
        {1'b1, 8'h01, 10'h100, 1'b0, 1'b0},
        {1'b0, 8'h23, 10'h023, 1'b1, 1'b0},
        {1'b0, 8'h24, 10'h124, 1'b0, 1'b0},
        {1'b1, 8'h24, 10'h124, 1'b0, 1'b0},
        {1'b1, 8'hFF, 10'h1FE, 1'b0, 1'b0},
        {1'b0, 8'hFF, 10'h1FF, 1'b0, 1'b0},
        {1'b1, 8'h23, 10'h122, 1'b0, 1'b0},
        {1'b1, 8'h00, 10'h000, 1'b1, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic probe(input logic w, input logic [7:0] a);
        is_word   = w;
        opnd_addr = a;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; opnd_addr = 0; is_word = 0; bank0_cmd = 0;
        insn_done = 0; sel_we = 0; sel_wdata = 0;
        @(negedge clk);
        tick();
        rst = 0;
        tick();

        // R5 boot value
        chk("R5 stack bank", 32'(stack_bank), 32'd1);
        probe(0, 8'h40);
        chk("R5 data bank", 32'(phys_addr), 32'h140);

        // vector table R1 R2 R3 R8 R9
        for (int i = 0; i < 12; i++) begin
            probe(VEC[i][20], VEC[i][19:12]);
            chk("R1/R2/R3 addr", 32'(phys_addr), 32'(VEC[i][11:2]));
            chk("R8 sfr_hit", 32'(sfr_hit), 32'(VEC[i][1]));
            chk("R9 zero_force", 32'(zero_force), 32'(VEC[i][0]));
        end

        // R6 write select: data bank 2, stack bank 3
        sel_we = 1; sel_wdata = 8'h32;
        tick();
        sel_we = 0;
        probe(0, 8'h80);
        chk("R6 data bank 2", 32'(phys_addr), 32'h280);
        chk("R6 stack bank 3", 32'(stack_bank), 32'd3);
        probe(0, 8'h11);
        chk("R3 sfr stays bank0", 32'(phys_addr), 32'h011);
        probe(1, 8'h41);
        chk("R10 redirect vs sel", 32'(phys_addr), 32'h140);

        // R4 upper field bits ignored: 0x0F -> data bank 3
        sel_we = 1; sel_wdata = 8'h0F;
        tick();
        sel_we = 0;
        probe(1, 8'h30);
        chk("R4 field upper bits ignored", 32'(phys_addr), 32'h330);
        chk("R5 stack bank follows", 32'(stack_bank), 32'd0);

        // R7 override
        bank0_cmd = 1;
        tick();
        bank0_cmd = 0;
        probe(0, 8'h30);
        chk("R7 override bank0", 32'(phys_addr), 32'h030);
        chk("R8 no sfr above window", 32'(sfr_hit), 32'd0);
        probe(1, 8'h33);
        chk("R10 redirect vs override", 32'(phys_addr), 32'h132);
        tick();
        probe(0, 8'h30);
        chk("R7 override held", 32'(phys_addr), 32'h030);
        insn_done = 1;
        tick();
        insn_done = 0;
        probe(0, 8'h30);
        chk("R7 override cleared", 32'(phys_addr), 32'h330);

        // R7 strobe and done together: set wins
        bank0_cmd = 1; insn_done = 1;
        tick();
        bank0_cmd = 0; insn_done = 0;
        probe(0, 8'hC0);
        chk("R7 set priority", 32'(phys_addr), 32'h0C0);
        insn_done = 1;
        tick();
        insn_done = 0;
        probe(0, 8'hC0);
        chk("R7 cleared after", 32'(phys_addr), 32'h3C0);

        // reset restores boot select
        rst = 1;
        tick();
        rst = 0;
        probe(0, 8'hC0);
        chk("R5 reset restores", 32'(phys_addr), 32'h1C0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule